// File: doc/BRIEF.md
# Edge-Change Interrupt Controller

The block watches a bank of digital input lines, grouped into byte-wide ports, and raises a level interrupt towards a host when a selected line changes. Every line first passes through a two-flop synchroniser. The block then compares each line with its value one clock earlier, which gives a rising and a falling indication for that line. Each port has its own rising-edge mask and its own falling-edge mask. A global enable for each polarity sits above the masks. An edge that passes both its mask and its polarity enable is called a qualifying edge.

A qualifying edge latches an edge-pending flag and records which polarity was seen. If a qualifying edge arrives while the edge-pending flag is still set, an overflow flag is also set. The host reads these flags through a status register. It acknowledges them by writing ones to a separate clear register. The interrupt line is a registered combination of the pending flags, their individual enables and a master enable. To arm the block, the host clears the flags and then writes the control byte with the wanted enables set.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, the control register, every mask register and every status flag read as zero, and `irq` and `bus_rdata` are 0.
- R2: The host bus decodes these addresses: control at 0x0, status at 0x1 (read only), clear at 0x2 (write only, reads as 0), the rising mask of port p at 0x4+p, and the falling mask of port p at 0x8+p. A read returns its data on `bus_rdata` one clock after `bus_rd` is sampled. In the control register only bits [4:0] are stored; the upper bits read as 0.
- R3: Input line i belongs to port i/8, at bit i%8 of that port's masks. A rising transition on line i is a qualifying edge when bit i%8 of port i/8's rising mask is 1 and control bit 3 (rising enable) is 1. A qualifying rising edge sets status bit 0 (edge pending) and status bit 3 (rising edge seen).
- R4: A falling transition on line i is a qualifying edge when the matching falling-mask bit is 1 and control bit 4 (falling enable) is 1. A qualifying falling edge sets status bit 0 and status bit 4 (falling edge seen).
- R5: An edge whose mask bit is 0, or whose polarity enable is 0, leaves every status bit unchanged.
- R6: A qualifying edge that arrives while status bit 0 is already 1 sets status bit 1 (overflow pending).
- R7: Writing the clear register works as follows. A 1 in bit 3 clears status bits 0, 3 and 4. A 1 in bit 2 clears status bit 1. No other bit of the written byte has any effect.
- R8: `irq` is 1 exactly when control bit 2 (master enable) is 1 and at least one of these holds: edge pending with control bit 0 set, or overflow pending with control bit 1 set. `irq` follows the flags one clock later, and status bit 2 reads the value of `irq`.
- R9: A qualifying edge that lands in the same clock as an edge-clear write wins. Edge pending stays 1, no overflow is recorded, and the seen bits show only the new edge.
- R10: With the control register at zero, no input activity changes any status bit and `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| lines_in | input | 32 | Monitored lines, lowest port in the low byte |
| irq | output | 1 | Level interrupt request |

## Verification
Two functions can act on the edge-pending flag in the same clock: a qualifying edge that reaches the detector, and a host write to the edge-clear bit. The bench changes an input line and then counts the synchroniser cycles, so that the clear write is sampled on exactly the clock edge where the detector updates the flags. The expected outcome is that the flag stays set, the overflow flag stays clear, and the seen bits show only the new edge. A bound property checks the same collision wherever the random stimulus produces it.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int CTRL_W = 5;

  // Clear-register bit positions
  localparam int CLR_OVF_BIT  = 2;
  localparam int CLR_EDGE_BIT = 3;

  // Control byte, bit 0 at the bottom
  typedef struct packed {
    logic fall_en;    // bit 4
    logic rise_en;    // bit 3
    logic master_en;  // bit 2
    logic ovf_en;     // bit 1
    logic edge_en;    // bit 0
  } ctrl_t;

  // Status byte, bit 0 at the bottom
  typedef struct packed {
    logic fall_seen;  // bit 4
    logic rise_seen;  // bit 3
    logic any_irq;    // bit 2
    logic ovf_pend;   // bit 1
    logic edge_pend;  // bit 0
  } status_t;
endpackage

// File: rtl/edge_line_detect.sv
module edge_line_detect #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lines,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stg [STAGES];
  logic [WIDTH-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= lines;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stg[LAST];
  end

  assign rise = stg[LAST] & ~prev_q;
  assign fall = ~stg[LAST] & prev_q;
endmodule

// File: rtl/edge_event_latch.sv
module edge_event_latch
  import edge_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  ctrl_t   ctrl,
  input  logic    rise_any,
  input  logic    fall_any,
  input  logic    clr_edge,
  input  logic    clr_ovf,
  output status_t status,
  output logic    qual,
  output logic    irq
);
  logic rise_hit, fall_hit;
  logic pend_q, ovf_q, rs_q, fs_q, irq_q;

  assign rise_hit = ctrl.rise_en & rise_any;
  assign fall_hit = ctrl.fall_en & fall_any;
  assign qual     = rise_hit | fall_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
      rs_q   <= 1'b0;
      fs_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      // a new event takes priority over an acknowledge in the same clock
      if (qual)          pend_q <= 1'b1;
      else if (clr_edge) pend_q <= 1'b0;

      // an event collides only with a pending event that is not retired now
      if (qual && pend_q && !clr_edge) ovf_q <= 1'b1;
      else if (clr_ovf)                ovf_q <= 1'b0;

      if (rise_hit)      rs_q <= 1'b1;
      else if (clr_edge) rs_q <= 1'b0;

      if (fall_hit)      fs_q <= 1'b1;
      else if (clr_edge) fs_q <= 1'b0;

      irq_q <= ctrl.master_en & ((pend_q & ctrl.edge_en) | (ovf_q & ctrl.ovf_en));
    end
  end

  assign status = '{fall_seen: fs_q, rise_seen: rs_q, any_irq: irq_q,
                    ovf_pend: ovf_q, edge_pend: pend_q};
  assign irq    = irq_q;
endmodule

// File: rtl/edge_reg_bank.sv
module edge_reg_bank
  import edge_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [PORT_W-1:0]           bus_wdata,
  input  logic                        bus_rd,
  output logic [PORT_W-1:0]           bus_rdata,
  input  status_t                     status,
  output ctrl_t                       ctrl,
  output logic [NUM_PORTS*PORT_W-1:0] rise_mask,
  output logic [NUM_PORTS*PORT_W-1:0] fall_mask,
  output logic                        clr_edge,
  output logic                        clr_ovf
);
  localparam int A_CTRL    = 0;
  localparam int A_STAT    = 1;
  localparam int A_CLR     = 2;
  localparam int RISE_BASE = 4;
  localparam int FALL_BASE = RISE_BASE + NUM_PORTS;

  ctrl_t             ctrl_q;
  logic [PORT_W-1:0] rise_q [NUM_PORTS];
  logic [PORT_W-1:0] fall_q [NUM_PORTS];
  logic [PORT_W-1:0] rd_mux;
  logic [PORT_W-1:0] rdata_q;
  logic              hit_clr;

  assign hit_clr  = bus_wr && (bus_addr == ADDR_W'(A_CLR));
  assign clr_edge = hit_clr && bus_wdata[CLR_EDGE_BIT];
  assign clr_ovf  = hit_clr && bus_wdata[CLR_OVF_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (bus_wr && bus_addr == ADDR_W'(A_CTRL)) begin
      ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end
  end

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_port
      always_ff @(posedge clk) begin
        if (rst) begin
          rise_q[p] <= '0;
          fall_q[p] <= '0;
        end else if (bus_wr) begin
          if (bus_addr == ADDR_W'(RISE_BASE + p)) rise_q[p] <= bus_wdata;
          if (bus_addr == ADDR_W'(FALL_BASE + p)) fall_q[p] <= bus_wdata;
        end
      end
      assign rise_mask[p*PORT_W +: PORT_W] = rise_q[p];
      assign fall_mask[p*PORT_W +: PORT_W] = fall_q[p];
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(A_CTRL)) rd_mux = PORT_W'(ctrl_q);
    if (bus_addr == ADDR_W'(A_STAT)) rd_mux = PORT_W'(status);
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (bus_addr == ADDR_W'(RISE_BASE + i)) rd_mux = rise_q[i];
      if (bus_addr == ADDR_W'(FALL_BASE + i)) rd_mux = fall_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign ctrl      = ctrl_q;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int PORT_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [PORT_W-1:0]           bus_wdata,
  input  logic                        bus_rd,
  output logic [PORT_W-1:0]           bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] lines_in,
  output logic                        irq
);
  localparam int LINES = NUM_PORTS * PORT_W;

  ctrl_t            ctrl_q;
  status_t          status;
  logic [LINES-1:0] rise_mask, fall_mask;
  logic [LINES-1:0] rise_vec, fall_vec;
  logic             rise_any, fall_any;
  logic             clr_edge, clr_ovf, qual;

  edge_reg_bank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .status(status), .ctrl(ctrl_q), .rise_mask(rise_mask),
    .fall_mask(fall_mask), .clr_edge(clr_edge), .clr_ovf(clr_ovf)
  );

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_det
      edge_line_detect #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_det (
        .clk(clk), .rst(rst),
        .lines(lines_in[p*PORT_W +: PORT_W]),
        .rise(rise_vec[p*PORT_W +: PORT_W]),
        .fall(fall_vec[p*PORT_W +: PORT_W])
      );
    end
  endgenerate

  assign rise_any = |(rise_vec & rise_mask);
  assign fall_any = |(fall_vec & fall_mask);

  edge_event_latch u_latch (
    .clk(clk), .rst(rst), .ctrl(ctrl_q), .rise_any(rise_any),
    .fall_any(fall_any), .clr_edge(clr_edge), .clr_ovf(clr_ovf),
    .status(status), .qual(qual), .irq(irq)
  );
endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] ctrl,
  input logic       edge_pend,
  input logic       ovf_pend,
  input logic       rise_seen,
  input logic       fall_seen,
  input logic       irq,
  input logic       qual,
  input logic       clr_edge,
  input logic       clr_ovf
);
  assert_rise_gated_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rise_seen) |-> $past(ctrl[3]));

  assert_fall_gated_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(fall_seen) |-> $past(ctrl[4]));

  assert_ovf_needs_pending_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_pend) |-> $past(edge_pend));

  assert_edge_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_edge && !qual) |=> (!edge_pend && !rise_seen && !fall_seen));

  assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_ovf && !edge_pend) |=> !ovf_pend);

  assert_master_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !ctrl[2] |=> !irq);

  assert_collision_R9: assert property (@(posedge clk) disable iff (rst)
    (qual && edge_pend && clr_edge && !clr_ovf) |=> (edge_pend && ovf_pend == $past(ovf_pend)));

  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (ctrl == 5'd0 && !edge_pend) |=> !edge_pend);
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .ctrl(ctrl_q),
  .edge_pend(status.edge_pend), .ovf_pend(status.ovf_pend),
  .rise_seen(status.rise_seen), .fall_seen(status.fall_seen),
  .irq(irq), .qual(qual), .clr_edge(clr_edge), .clr_ovf(clr_ovf)
);

// File: tb/edge_irq_ctrl_bench.sv
module edge_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [31:0] lines_in = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [4:0]  m_ctrl = '0;
  logic [31:0] m_rmask = '0, m_fmask = '0;
  logic [31:0] m_lines = '0;
  logic        m_pend = 0, m_ovf = 0, m_rs = 0, m_fs = 0;

  always #2 clk = ~clk;

  edge_irq_ctrl u_edge_irq_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .lines_in(lines_in), .irq(irq)
  );

  function automatic logic m_irq();
    return m_ctrl[2] & ((m_pend & m_ctrl[0]) | (m_ovf & m_ctrl[1]));
  endfunction

  function automatic logic [7:0] m_status();
    return {3'b000, m_fs, m_rs, m_irq(), m_ovf, m_pend};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 4'h0) m_ctrl = d[4:0];
    if (a == 4'h2) begin
      if (d[3]) begin m_pend = 0; m_rs = 0; m_fs = 0; end
      if (d[2]) m_ovf = 0;
    end
    for (int p = 0; p < 4; p++) begin
      if (a == 4'(4 + p)) m_rmask[p*8 +: 8] = d;
      if (a == 4'(8 + p)) m_fmask[p*8 +: 8] = d;
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic void model_edge(input logic [31:0] nv, output logic rh, output logic fh);
    logic [31:0] r, f;
    r = nv & ~m_lines;
    f = ~nv & m_lines;
    rh = m_ctrl[3] & |(r & m_rmask);
    fh = m_ctrl[4] & |(f & m_fmask);
    m_lines = nv;
  endfunction

  task automatic apply(input logic [31:0] nv);
    logic rh, fh;
    @(negedge clk);
    lines_in = nv;
    model_edge(nv, rh, fh);
    if (rh | fh) begin
      if (m_pend) m_ovf = 1;
      m_pend = 1;
    end
    if (rh) m_rs = 1;
    if (fh) m_fs = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic check_status(input string tag);
    logic [7:0] d;
    rd(4'h1, d);
    check({tag, " status"}, {24'd0, d}, {24'd0, m_status()});
    check({tag, " irq"}, {31'd0, irq}, {31'd0, m_irq()});
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic rh, fh;
    void'($urandom(32'd4051));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", {24'd0, bus_rdata}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(4'h0, d); check("R1 ctrl", {24'd0, d}, 32'd0);
    rd(4'h1, d); check("R1 status", {24'd0, d}, 32'd0);
    for (int a = 4; a < 12; a++) begin
      rd(4'(a), d); check("R1 mask", {24'd0, d}, 32'd0);
    end

    // R2 register readback
    wr(4'h0, 8'hFF); rd(4'h0, d); check("R2 ctrl upper bits", {24'd0, d}, 32'h1F);
    wr(4'h0, 8'h00);
    for (int a = 4; a < 12; a++) begin
      logic [7:0] v;
      v = 8'($urandom);
      wr(4'(a), v); rd(4'(a), d); check("R2 mask readback", {24'd0, d}, {24'd0, v});
    end
    rd(4'h2, d); check("R2 clear reads zero", {24'd0, d}, 32'd0);
    for (int a = 4; a < 12; a++) wr(4'(a), 8'h00);

    // arm: clear then enable edge, master, rise, fall
    wr(4'h2, 8'h0C); wr(4'h0, 8'h1D);
    wr(4'h4, 8'h01);   // line 0 rising
    wr(4'h9, 8'h80);   // line 15 falling
    wr(4'h6, 8'h10);   // line 20 rising
    apply(32'h0000_0001);
    check_status("R3 line0 rise");
    check("R3 pend+rise bits", {24'd0, m_status()}, 32'h0D);
    wr(4'h2, 8'h08); check_status("R7 edge clear");
    apply(32'h0010_8001);  // line 20 rises (port 2 bit 4), line 15 rises (no mask)
    check_status("R3 line20 rise");
    wr(4'h2, 8'h08);
    apply(32'h0010_0001);  // line 15 falls
    check_status("R4 line15 fall");
    check("R4 fall bit", {31'd0, m_status()[4]}, 32'd1);
    wr(4'h2, 8'h08);
    apply(32'h0010_0003);  // line 1 rises, not masked
    check_status("R5 unmasked line");
    check("R5 no pend", {31'd0, m_pend}, 32'd0);
    wr(4'h0, 8'h15);       // rise enable off
    apply(32'h0010_0002);  // line 0 falls (unmasked for fall)
    apply(32'h0010_0003);  // line 0 rises with rise disabled
    check_status("R5 polarity disabled");

    // R6 overflow, R8 gating
    wr(4'h0, 8'h1D);
    apply(32'h0010_0002);  // line 0 falls: no fall mask
    apply(32'h0010_0003);  // rise -> pend
    apply(32'h0010_0002);
    apply(32'h0010_0003);  // second rise -> overflow
    check_status("R6 overflow");
    check("R6 ovf set", {31'd0, m_ovf}, 32'd1);
    wr(4'h0, 8'h06); check_status("R8 ovf only irq");
    wr(4'h0, 8'h03); check_status("R8 master off");
    wr(4'h2, 8'hF3); check_status("R7 other bits ignored");
    wr(4'h2, 8'h04); check_status("R7 ovf clear");
    wr(4'h0, 8'h06); check_status("R8 edge en off");
    wr(4'h0, 8'h1D); check_status("R8 edge en on");

    // R9 collision: edge sampled in the same clock as edge clear
    @(negedge clk);
    lines_in = 32'h0010_0002;
    model_edge(32'h0010_0002, rh, fh);
    apply(32'h0010_0002);
    @(negedge clk);
    lines_in = 32'h0010_0003;
    model_edge(32'h0010_0003, rh, fh);
    @(negedge clk);
    @(negedge clk);
    bus_addr = 4'h2; bus_wdata = 8'h08; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    m_pend = 1; m_rs = rh; m_fs = fh;
    repeat (3) @(negedge clk);
    check_status("R9 collision");
    check("R9 no overflow", {31'd0, m_ovf}, 32'd0);

    // R10 control zero
    wr(4'h2, 8'h0C); wr(4'h0, 8'h00);
    for (int k = 0; k < 6; k++) apply(32'($urandom));
    check_status("R10 idle");

    // random mix
    for (int k = 0; k < 200; k++) begin
      int sel;
      sel = int'($urandom % 10);
      if (sel < 6) apply(m_lines ^ (32'd1 << ($urandom % 32)) ^ (($urandom % 4 == 0) ? 32'($urandom) : 32'd0));
      else if (sel == 6) wr(4'h2, 8'($urandom));
      else if (sel == 7) wr(4'h0, 8'($urandom));
      else wr(4'(4 + $urandom % 8), 8'($urandom));
      check_status("R3 R4 R6 R8 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule